// File: doc/BRIEF.md
# Self-Referenced Delay-Line XOR Frequency Detector

This block produces the error bit stream for a drift stabilizer that holds a free-running oscillator near one of a comb of stable frequencies. A prescaler divides the system clock to make a sample strobe. On each strobe the block takes one sample of the synchronized oscillator input and stores it in a delay line N samples long. It then outputs, through a register, the XOR of the new sample with the sample stored N strobes before it. An external RC network averages this stream into the tuning voltage.

The detector compares the oscillator with a delayed copy of itself, not with a reference edge. Stable points therefore fall at every multiple of the sample rate divided by N. Away from those points the stream is close to 50% ones.

N may be any whole number up to the buffer size, not only a multiple of eight. This allows the step size to be set finely.

Top module: `dlx_detector`

## Requirements
- R1: While rst_n is low, det_out is 0. The strobe counter, the write position and the fill count restart from zero. Release of reset takes effect at a clock edge.
- R2: The value sampled at a strobe edge is the osc_in level that was present at the clock edge two edges earlier (two synchronizer flops).
- R3: The strobe occurs once every R clock edges, where R = prescale, and prescale 0 counts as 1. The first strobe falls on the R-th edge after reset release. If prescale is lowered while counting, the next strobe fires as soon as the count has reached the new ratio.
- R4: det_out changes only on an edge that carries a strobe or a length restart. On every other edge it holds its value.
- R5: Once the line is full, det_out after a strobe edge equals the new sample XOR the sample taken exactly N strobes earlier.
- R6: For the first N strobes after reset or after a restart, det_out is driven to 0.
- R7: When the effective delay length differs from the one in use, the next edge restarts the line. That edge clears det_out, sets the write position and the fill count to zero, and takes no sample. The strobe cadence is not disturbed.
- R8: The effective length is delay_len for any value from 1 to MAX_LEN, including values that are not multiples of 8. A delay_len of 0 acts as 1. Values above MAX_LEN (default 512) act as MAX_LEN.
- R9: An input whose period in samples divides N gives a constant 0 once the line is full. An input offset by half a period over N samples gives a constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divided reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Conditioned oscillator level, asynchronous |
| prescale | input | PRE_W (16) | Clock edges per sample strobe |
| delay_len | input | LEN_W (10) | Delay length N in samples |
| det_out | output | 1 | Registered XOR detector output |

## Verification
A length restart and a sample strobe can land on the same edge. With prescale at 1 every edge is a strobe, so each change of delay_len in those runs creates the collision. The check requires that the restart wins: det_out clears, nothing is written, and the next N outputs are 0. A lowered prescale can also make a strobe coincide with the restart edge. That case is judged the same way against a bench model that follows the counting rule of R3.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

  typedef enum logic {
    PH_LOADING = 1'b0,
    PH_FULL    = 1'b1
  } fill_phase_e;

  function automatic logic [31:0] dlx_clamp_len(input logic [31:0] req,
                                                input logic [31:0] max_len);
    logic [31:0] res;
    if (req == 32'd0) begin
      res = 32'd1;
    end else if (req > max_len) begin
      res = max_len;
    end else begin
      res = req;
    end
    return res;
  endfunction

endpackage

// File: rtl/dlx_sync.sv
module dlx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = async_in;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dlx_strobe_gen.sv
module dlx_strobe_gen #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] ratio,
  output logic             strobe
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] last_cnt;

  always_comb begin
    if (ratio == '0) begin
      last_cnt = '0;
    end else begin
      last_cnt = ratio - PRE_W'(1);
    end
    strobe = (cnt_q >= last_cnt);
    if (strobe) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dlx_delay_line.sv
module dlx_delay_line
  import dlx_pkg::*;
#(
  parameter int unsigned MAX_LEN = 512,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
  parameter int unsigned PTR_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_req,
  input  logic             strobe,
  input  logic             sample,
  output logic             det_out,
  output logic             restart,
  output logic             line_full,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [LEN_W-1:0] eff_len
);

  logic [MAX_LEN-1:0] line_q;
  logic [MAX_LEN-1:0] line_d;
  logic [PTR_W-1:0]   ptr_q;
  logic [PTR_W-1:0]   ptr_d;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   fill_q;
  logic [LEN_W-1:0]   fill_d;
  logic [LEN_W-1:0]   fill_inc;
  logic [LEN_W-1:0]   ptr_inc;
  fill_phase_e        phase_q;
  fill_phase_e        phase_d;
  logic               det_q;
  logic               det_d;
  logic               oldest;
  logic               take;

  always_comb begin
    eff_len  = LEN_W'(dlx_clamp_len(32'(len_req), 32'(MAX_LEN)));
    restart  = (eff_len != len_q);
    take     = strobe && !restart;
    oldest   = line_q[ptr_q];
    ptr_inc  = LEN_W'(ptr_q) + LEN_W'(1);
    fill_inc = fill_q + LEN_W'(1);

    line_d  = line_q;
    ptr_d   = ptr_q;
    fill_d  = fill_q;
    phase_d = phase_q;
    det_d   = det_q;

    if (restart) begin
      ptr_d   = '0;
      fill_d  = '0;
      phase_d = PH_LOADING;
      det_d   = 1'b0;
    end else if (take) begin
      line_d[ptr_q] = sample;
      if (ptr_inc >= eff_len) begin
        ptr_d = '0;
      end else begin
        ptr_d = PTR_W'(ptr_inc);
      end
      if (phase_q == PH_FULL) begin
        det_d = sample ^ oldest;
      end else begin
        det_d  = 1'b0;
        fill_d = fill_inc;
        if (fill_inc == eff_len) begin
          phase_d = PH_FULL;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      fill_q  <= '0;
      len_q   <= LEN_W'(1);
      phase_q <= PH_LOADING;
      det_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      fill_q  <= fill_d;
      len_q   <= eff_len;
      phase_q <= phase_d;
      det_q   <= det_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      line_q <= line_d;
    end
  end

  assign det_out   = det_q;
  assign line_full = (phase_q == PH_FULL);
  assign wr_ptr    = ptr_q;

endmodule

// File: rtl/dlx_detector.sv
module dlx_detector #(
  parameter int unsigned MAX_LEN = 512,
  parameter int unsigned PRE_W   = 16,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic [PRE_W-1:0] prescale,
  input  logic [LEN_W-1:0] delay_len,
  output logic             det_out
);

  localparam int unsigned PTR_W = $clog2(MAX_LEN);

  logic             osc_sync;
  logic             smp_strobe;
  logic             len_restart;
  logic             line_full;
  logic [PTR_W-1:0] wr_ptr;
  logic [LEN_W-1:0] eff_len;

  dlx_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (osc_in),
    .sync_out (osc_sync)
  );

  dlx_strobe_gen #(.PRE_W(PRE_W)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .ratio  (prescale),
    .strobe (smp_strobe)
  );

  dlx_delay_line #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .PTR_W   (PTR_W)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_req   (delay_len),
    .strobe    (smp_strobe),
    .sample    (osc_sync),
    .det_out   (det_out),
    .restart   (len_restart),
    .line_full (line_full),
    .wr_ptr    (wr_ptr),
    .eff_len   (eff_len)
  );

endmodule

// File: rtl/dlx_detector_chk.sv
module dlx_detector_chk #(
  parameter int unsigned MAX_LEN = 512,
  parameter int unsigned PRE_W   = 16,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
  parameter int unsigned PTR_W   = $clog2(MAX_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PRE_W-1:0] prescale,
  input logic             det_out,
  input logic             strobe,
  input logic             restart,
  input logic             line_full,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [LEN_W-1:0] eff_len
);

  assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && prescale > PRE_W'(1)) |=> (!strobe || !$stable(prescale)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !restart) |=> $stable(det_out));

  assert_fill_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !restart && !line_full) |=> !det_out);

  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !det_out);

  assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (LEN_W'(wr_ptr) < eff_len));

endmodule

bind dlx_detector dlx_detector_chk #(
  .MAX_LEN (MAX_LEN),
  .PRE_W   (PRE_W),
  .LEN_W   (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prescale  (prescale),
  .det_out   (det_out),
  .strobe    (smp_strobe),
  .restart   (len_restart),
  .line_full (line_full),
  .wr_ptr    (wr_ptr),
  .eff_len   (eff_len)
);

// File: tb/dlx_detector_tb.sv
module dlx_detector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 512;

  logic        clk;
  logic        rst_n;
  logic        osc_in;
  logic [15:0] prescale;
  logic [9:0]  delay_len;
  logic        det_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  int    m_cnt, m_ptr, m_fill, m_lq;
  bit    m_q1, m_q2, m_exp;
  bit    m_line [0:MAXL-1];
  string seg_tag;
  string next_tag;

  dlx_detector u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_in    (osc_in),
    .prescale  (prescale),
    .delay_len (delay_len),
    .det_out   (det_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int clamp_len(input int v);
    if (v == 0) return 1;
    if (v > MAXL) return MAXL;
    return v;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: det_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs for the coming edge and advance the model across it
  task automatic step(input bit o, input int pre, input int len);
    int r, l;
    bit s, stb, old;
    osc_in    = o;
    prescale  = 16'(pre);
    delay_len = 10'(len);
    r   = (pre == 0) ? 1 : pre;
    l   = clamp_len(len);
    s   = m_q2;
    stb = (m_cnt >= r - 1);
    if (l != m_lq) begin
      m_ptr = 0; m_fill = 0; m_exp = 0; next_tag = "R7";
    end else if (stb) begin
      old = m_line[m_ptr];
      if (m_fill >= l) begin
        m_exp = s ^ old; next_tag = seg_tag;
      end else begin
        m_exp = 0; next_tag = "R6"; m_fill++;
      end
      m_line[m_ptr] = s;
      m_ptr = (m_ptr + 1 >= l) ? 0 : m_ptr + 1;
    end else begin
      next_tag = "R4";
    end
    m_cnt = stb ? 0 : m_cnt + 1;
    m_lq  = l;
    m_q2  = m_q1;
    m_q1  = o;
  endtask

  task automatic cycle(input bit o, input int pre, input int len);
    @(negedge clk);
    check(next_tag, det_out, m_exp);
    step(o, pre, len);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; osc_in = 1'b1; prescale = 16'd1; delay_len = 10'd1;
    repeat (3) @(negedge clk);
    check("R1", det_out, 1'b0);
    m_cnt = 0; m_ptr = 0; m_fill = 0; m_lq = 1;
    m_q1 = 0; m_q2 = 0; m_exp = 0;
    next_tag = "R1";
    rst_n = 1'b1;
    step(1'b0, 1, 1);
  endtask

  // mode 0: random bits, mode 1: square wave with period per clock
  task automatic run_seg(input int pre, input int len, input int mode,
                         input int per, input int ncyc, input string tag);
    seg_tag = tag;
    for (int i = 0; i < ncyc; i++) begin
      bit o;
      if (mode == 0) o = 1'($urandom_range(0, 1));
      else o = ((i % per) < (per / 2));
      cycle(o, pre, len);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; osc_in = 1'b0; prescale = 16'd1; delay_len = 10'd1;
    seg_tag = "R5"; next_tag = "R1";
    do_reset();

    // R2: length 1, strobe every edge, exposes synchronizer latency
    run_seg(1, 1, 0, 0, 200, "R2");
    // R9: stable point (period 8 divides 16) and half-period offset (12)
    run_seg(1, 16, 1, 8, 200, "R9");
    run_seg(1, 12, 1, 8, 200, "R9");
    // R3: divided strobes, then ratio lowered mid-count
    run_seg(4, 20, 0, 0, 300, "R3");
    run_seg(7, 9, 0, 0, 200, "R3");
    run_seg(1, 9, 0, 0, 100, "R3");
    run_seg(0, 9, 0, 0, 100, "R3");
    // R8: odd length, zero length, clamped length
    run_seg(1, 293, 0, 0, 800, "R8");
    run_seg(2, 0, 0, 0, 100, "R8");
    run_seg(2, 600, 0, 0, 1200, "R8");
    run_seg(1, 512, 0, 0, 700, "R8");
    // R7 with strobe on the same edge, mid-fill change
    run_seg(1, 40, 0, 0, 20, "R7");
    run_seg(1, 41, 0, 0, 100, "R7");

    // random mix, R5
    for (int k = 0; k < 40; k++) begin
      int pre, len;
      pre = $urandom_range(1, 5);
      len = $urandom_range(1, 70);
      run_seg(pre, len, 0, 0, (len + 25) * pre * 2, "R5");
    end

    // R1 again mid-run
    do_reset();
    run_seg(3, 25, 0, 0, 300, "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule